// File: doc/BRIEF.md
# Byte-Wise Serial NOR Flash Controller

This block lets a host reach an external serial NOR flash one byte at a time through a small word-spaced register file on a 32-bit register bus. The host loads a 24-bit flash address, a byte to program or a run of up to six opcode and argument bytes, and then writes a command register. The controller runs the matching SPI transaction on a single-bit master port, and it returns any fetched byte in a readable register.

Each operation is started by a one-hot bit in the command register. That bit stays set while the transaction runs and clears itself when the transaction ends, so the host polls the register to know when the operation is complete. An optional qualifier bit makes byte reads and byte writes step the address forward by one. A write-protect key register must hold 0x30 before any command is taken. A generic program mode sends a bit-counted run of bytes, which covers write-enable, sector erase and similar flash opcodes.

Top module: `nor_pio_ctrl`

## Requirements
- R1: After reset, every register reads zero, spiCsN is high and spiSck is low.
- R2: A write to the command register (offset 0x00) starts nothing and leaves the register at zero unless the key register (offset 0xC4) holds exactly 0x30.
- R3: Command bit 0 (byte read) runs one chip-select frame carrying opcode 0x03 and the 24-bit address, high byte first, and then samples 8 bits from spiMiso. The sampled byte appears in the read-data register (offset 0x0C).
- R4: Command bit 1 (status read) runs one frame carrying opcode 0x05 and then samples 8 bits into the status register (offset 0x08).
- R5: Command bit 4 (byte write) runs a frame that carries only 0x06, then a second frame carrying 0x02, the address and the write-data byte (offset 0x1C).
- R6: Command bit 5 (status write) runs a frame carrying only 0x06, then a second frame carrying 0x01 followed by the write-data byte.
- R7: Command bit 2 (program) sends as many bits as the 8-bit count register (offset 0x04) holds. The bits start at the MSB of program byte 5 (offset 0x34) and continue down to program byte 0 (offset 0x20).
- R8: A program command whose count is 0 or greater than 48 clears itself without pulling spiCsN low.
- R9: With bit 7 set next to bit 0 or bit 4, the 24-bit address (bytes at 0x10 low, 0x14 middle, 0x18 high) increases by one after the byte completes, and the carry crosses byte boundaries. With any other operation, bit 7 changes nothing.
- R10: The command register reads back the operation bit and bit 7 while the operation runs. All of its bits clear on the cycle the last frame ends. A command write that arrives while an operation runs is ignored, including one on the completion cycle itself.
- R11: When several operation bits are written together, only the lowest-numbered one is kept and run.
- R12: The link uses SPI mode 0, MSB first. spiSck is low whenever spiCsN is high, spiMosi changes only while spiSck is low, and spiMiso is sampled on the rising edge. Each spiSck period lasts 2·2^CLK_DIV_LOG2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Flash serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
A host command write can land on the same edge where a running operation finishes and its busy bit clears. The bench counts rising edges of spiSck during a byte read and places a status-read command exactly on the final falling-edge cycle. It then checks that the command register reads zero afterwards and that no extra chip-select frame appears. A second case collides an address-byte carry with the auto-increment step: a read at address 0x1234FF must leave 0x123500.

// File: rtl/nor_pio_pkg.sv
package nor_pio_pkg;

  // Command register bit positions (host visible)
  localparam int OP_READ   = 0;
  localparam int OP_STAT   = 1;
  localparam int OP_PRG    = 2;
  localparam int OP_WRITE  = 4;
  localparam int OP_WRSR   = 5;
  localparam int OP_AUTO   = 7;
  localparam logic [7:0] OP_MASK = 8'h37;

  // Register offsets
  localparam logic [7:0] OFF_CMD     = 8'h00;
  localparam logic [7:0] OFF_COUNT   = 8'h04;
  localparam logic [7:0] OFF_STATUS  = 8'h08;
  localparam logic [7:0] OFF_RDATA   = 8'h0C;
  localparam logic [7:0] OFF_ADDR    = 8'h10;
  localparam logic [7:0] OFF_WDATA   = 8'h1C;
  localparam logic [7:0] OFF_PRG     = 8'h20;
  localparam logic [7:0] OFF_PROTECT = 8'hC4;

  localparam logic [31:0] PROTECT_KEY = 32'h30;

  typedef enum logic [2:0] {
    FR_READ, FR_STATUS, FR_PROG, FR_WREN, FR_PAGE, FR_WRSR
  } frameSel_t;

  typedef struct packed {
    logic      frameStart;
    frameSel_t frameSel;
    logic      capRead;
    logic      capStatus;
    logic      addrInc;
  } ctrlStrobe_t;

endpackage

// File: rtl/nor_pio_dp.sv
module nor_pio_dp
  import nor_pio_pkg::*;
#(
  parameter int CLK_DIV_LOG2 = 1,
  parameter int PRG_N        = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  cmdReg,
  output logic [31:0] regRdata,
  output logic        frameDone,
  output logic        protectOk,
  output logic        prgCountOk,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);

  localparam int FRAME_W = PRG_N * 8;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int HALF    = 1 << CLK_DIV_LOG2;
  localparam int PH_W    = (CLK_DIV_LOG2 > 0) ? CLK_DIV_LOG2 : 1;
  localparam int ADDR_B  = 3;

  logic [7:0]           bitCount;
  logic [7:0]           statusByte;
  logic [7:0]           readByte;
  logic [7:0]           writeByte;
  logic [ADDR_B*8-1:0]  addrReg;
  logic [ADDR_B*8-1:0]  addrNext;
  logic [FRAME_W-1:0]   prgFlat;
  logic [31:0]          protectReg;

  // Serial engine state
  logic                 active;
  logic                 sckReg;
  logic [PH_W-1:0]      phase;
  logic [FRAME_W-1:0]   shiftReg;
  logic [LEN_W-1:0]     bitsLeft;
  logic [7:0]           rxShift;
  logic                 tick;
  logic [FRAME_W-1:0]   frameVec;
  logic [LEN_W-1:0]     frameLen;

  assign protectOk  = (protectReg == PROTECT_KEY);
  assign prgCountOk = (bitCount != 8'd0) && (bitCount <= 8'(FRAME_W));

  // Host register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount   <= '0;
      writeByte  <= '0;
      protectReg <= '0;
      prgFlat    <= '0;
    end else if (regWrEn) begin
      if (regAddr == OFF_COUNT)   bitCount   <= regWdata[7:0];
      if (regAddr == OFF_WDATA)   writeByte  <= regWdata[7:0];
      if (regAddr == OFF_PROTECT) protectReg <= regWdata;
      for (int k = 0; k < PRG_N; k++) begin
        if (regAddr == OFF_PRG + 8'(4 * k)) prgFlat[8*k +: 8] <= regWdata[7:0];
      end
    end
  end

  // Address: increment first, then any host byte write overrides its byte
  always_comb begin
    addrNext = strobe.addrInc ? addrReg + 1'b1 : addrReg;
    for (int k = 0; k < ADDR_B; k++) begin
      if (regWrEn && regAddr == OFF_ADDR + 8'(4 * k)) addrNext[8*k +: 8] = regWdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      readByte   <= '0;
      statusByte <= '0;
    end else begin
      addrReg <= addrNext;
      if (strobe.capRead)   readByte   <= rxShift;
      if (strobe.capStatus) statusByte <= rxShift;
    end
  end

  // Frame contents, MSB aligned
  always_comb begin
    frameVec = '0;
    frameLen = '0;
    unique case (strobe.frameSel)
      FR_READ:   begin frameVec = {8'h03, addrReg, {(FRAME_W-32){1'b0}}}; frameLen = LEN_W'(40); end
      FR_STATUS: begin frameVec = {8'h05, {(FRAME_W-8){1'b0}}};           frameLen = LEN_W'(16); end
      FR_PROG:   begin frameVec = prgFlat;                                frameLen = bitCount[LEN_W-1:0]; end
      FR_WREN:   begin frameVec = {8'h06, {(FRAME_W-8){1'b0}}};           frameLen = LEN_W'(8); end
      FR_PAGE:   begin frameVec = {8'h02, addrReg, writeByte, {(FRAME_W-40){1'b0}}}; frameLen = LEN_W'(40); end
      FR_WRSR:   begin frameVec = {8'h01, writeByte, {(FRAME_W-16){1'b0}}}; frameLen = LEN_W'(16); end
      default:   begin frameVec = '0; frameLen = '0; end
    endcase
  end

  assign tick      = active && (phase == PH_W'(HALF - 1));
  assign frameDone = tick && sckReg && (bitsLeft == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      sckReg   <= 1'b0;
      phase    <= '0;
      shiftReg <= '0;
      bitsLeft <= '0;
      rxShift  <= '0;
    end else if (strobe.frameStart) begin
      active   <= 1'b1;
      sckReg   <= 1'b0;
      phase    <= '0;
      shiftReg <= frameVec;
      bitsLeft <= frameLen;
    end else if (active) begin
      if (tick) begin
        phase <= '0;
        if (!sckReg) begin
          sckReg  <= 1'b1;
          rxShift <= {rxShift[6:0], spiMiso};
        end else begin
          sckReg   <= 1'b0;
          shiftReg <= shiftReg << 1;
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == LEN_W'(1)) active <= 1'b0;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign spiCsN  = !active;
  assign spiSck  = sckReg;
  assign spiMosi = active & shiftReg[FRAME_W-1];

  // Register read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_CMD:       regRdata = {24'h0, cmdReg};
      OFF_COUNT:     regRdata = {24'h0, bitCount};
      OFF_STATUS:    regRdata = {24'h0, statusByte};
      OFF_RDATA:     regRdata = {24'h0, readByte};
      OFF_WDATA:     regRdata = {24'h0, writeByte};
      OFF_PROTECT:   regRdata = protectReg;
      default:       regRdata = '0;
    endcase
    for (int k = 0; k < ADDR_B; k++) begin
      if (regAddr == OFF_ADDR + 8'(4 * k)) regRdata = {24'h0, addrReg[8*k +: 8]};
    end
    for (int k = 0; k < PRG_N; k++) begin
      if (regAddr == OFF_PRG + 8'(4 * k)) regRdata = {24'h0, prgFlat[8*k +: 8]};
    end
  end

endmodule

// File: rtl/nor_pio_ctl.sv
module nor_pio_ctl
  import nor_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regWbyte,
  input  logic        protectOk,
  input  logic        prgCountOk,
  input  logic        frameDone,
  output ctrlStrobe_t strobe,
  output logic [7:0]  cmdReg
);

  typedef enum logic [2:0] {S_IDLE, S_LAUNCH1, S_RUN1, S_LAUNCH2, S_RUN2} state_t;

  state_t     state;
  logic [7:0] opBits;
  logic [7:0] opPick;
  logic       accept;
  logic       twoFrame;
  logic       prgSkip;

  assign opBits   = regWbyte & OP_MASK;
  assign opPick   = opBits & (~opBits + 8'd1);
  assign accept   = (state == S_IDLE) && regWrEn && (regAddr == OFF_CMD) && protectOk && (opPick != 8'd0);
  assign twoFrame = cmdReg[OP_WRITE] | cmdReg[OP_WRSR];
  assign prgSkip  = cmdReg[OP_PRG] && !prgCountOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cmdReg <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          cmdReg <= opPick | {regWbyte[OP_AUTO], 7'h0};
          state  <= S_LAUNCH1;
        end
        S_LAUNCH1: if (prgSkip) begin
          cmdReg <= '0;
          state  <= S_IDLE;
        end else begin
          state <= S_RUN1;
        end
        S_RUN1: if (frameDone) begin
          if (twoFrame) state <= S_LAUNCH2;
          else begin
            cmdReg <= '0;
            state  <= S_IDLE;
          end
        end
        S_LAUNCH2: state <= S_RUN2;
        S_RUN2: if (frameDone) begin
          cmdReg <= '0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    strobe.frameSel = FR_READ;
    if (state == S_LAUNCH1) begin
      strobe.frameStart = !prgSkip;
      if (cmdReg[OP_STAT])     strobe.frameSel = FR_STATUS;
      else if (cmdReg[OP_PRG]) strobe.frameSel = FR_PROG;
      else if (twoFrame)       strobe.frameSel = FR_WREN;
    end else if (state == S_LAUNCH2) begin
      strobe.frameStart = 1'b1;
      strobe.frameSel   = cmdReg[OP_WRSR] ? FR_WRSR : FR_PAGE;
    end
    strobe.capRead   = (state == S_RUN1) && frameDone && cmdReg[OP_READ];
    strobe.capStatus = (state == S_RUN1) && frameDone && cmdReg[OP_STAT];
    strobe.addrInc   = frameDone && cmdReg[OP_AUTO] &&
                       (((state == S_RUN1) && cmdReg[OP_READ]) ||
                        ((state == S_RUN2) && cmdReg[OP_WRITE]));
  end

endmodule

// File: rtl/nor_pio_ctrl.sv
module nor_pio_ctrl
  import nor_pio_pkg::*;
#(
  parameter int CLK_DIV_LOG2 = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);

  ctrlStrobe_t strobe;
  logic [7:0]  cmdReg;
  logic        frameDone;
  logic        protectOk;
  logic        prgCountOk;

  nor_pio_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWbyte   (regWdata[7:0]),
    .protectOk  (protectOk),
    .prgCountOk (prgCountOk),
    .frameDone  (frameDone),
    .strobe     (strobe),
    .cmdReg     (cmdReg)
  );

  nor_pio_dp #(.CLK_DIV_LOG2(CLK_DIV_LOG2), .PRG_N(6)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .strobe     (strobe),
    .cmdReg     (cmdReg),
    .regRdata   (regRdata),
    .frameDone  (frameDone),
    .protectOk  (protectOk),
    .prgCountOk (prgCountOk),
    .spiCsN     (spiCsN),
    .spiSck     (spiSck),
    .spiMosi    (spiMosi),
    .spiMiso    (spiMiso)
  );

endmodule

// File: rtl/nor_pio_ctrl_chk.sv
module nor_pio_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regAddr,
  input logic [7:0] cmdReg,
  input logic       protectOk,
  input logic       spiCsN,
  input logic       spiSck,
  input logic       spiMosi
);

  logic [7:0] cmdOps;
  assign cmdOps = cmdReg & 8'h37;

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);  // R12

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSck && $past(spiSck)) |-> $stable(spiMosi));  // R12

  AST_NO_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOps == 8'h00) |-> spiCsN);  // R10

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOps));  // R11

  AST_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h00 && !protectOk && cmdOps == 8'h00) |=> (cmdOps == 8'h00));  // R2

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h00 && cmdOps != 8'h00) |=> (cmdOps == 8'h00 || cmdOps == $past(cmdOps)));  // R10

endmodule

bind nor_pio_ctrl nor_pio_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .cmdReg    (cmdReg),
  .protectOk (protectOk),
  .spiCsN    (spiCsN),
  .spiSck    (spiSck),
  .spiMosi   (spiMosi)
);

// File: tb/nor_pio_ctrl_bench.sv
module nor_pio_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        spiCsN, spiSck, spiMosi;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;
  int frameCount = 0;
  int cycles = 0;
  bit monitorOn = 1'b0;

  always #2 clk = ~clk;

  nor_pio_ctrl u_nor_pio_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // Scoreboard queues: expected frames, right aligned
  logic [63:0] expBits[$];
  int          expLen[$];

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic pushFrame(logic [63:0] bits, int n);
    expBits.push_back(bits);
    expLen.push_back(n);
  endtask

  function automatic logic [7:0] flashByte(logic [23:0] a);
    return (a[7:0] ^ a[23:16]) + 8'h11;
  endfunction

  // Flash model and monitor
  logic [63:0] rxBits;
  int          rxCnt;
  logic [7:0]  opByte;
  logic [23:0] addrSeen;
  logic [7:0]  flashStatus = 8'hA5;
  logic [7:0]  dByte;

  always @(negedge spiCsN) begin
    rxBits = '0; rxCnt = 0; opByte = '0; addrSeen = '0; spiMiso = 1'b0;
  end

  always @(posedge spiSck) if (!spiCsN) begin
    rxBits = {rxBits[62:0], spiMosi};
    rxCnt++;
    if (rxCnt == 8) opByte = rxBits[7:0];
    if (rxCnt == 32) addrSeen = rxBits[23:0];
  end

  always @(negedge spiSck) if (!spiCsN) begin
    dByte = flashByte(addrSeen);
    if (opByte == 8'h05 && rxCnt >= 8 && rxCnt < 16) spiMiso = flashStatus[15-rxCnt];
    else if (opByte == 8'h03 && rxCnt >= 32 && rxCnt < 40) spiMiso = dByte[39-rxCnt];
    else spiMiso = 1'b0;
  end

  always @(posedge spiCsN) if (monitorOn) begin
    frameCount++;
    if (expLen.size() == 0) begin
      checks++; errors++;
      $display("FAIL R3 unexpected frame got=%0h exp=none", rxBits);
    end else begin
      automatic int n = expLen.pop_front();
      automatic logic [63:0] b = expBits.pop_front();
      check("R12 frame length", 64'(rxCnt), 64'(n));
      check("R3 frame bits", rxBits, b);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(8'h00, v);
      if ((v & 32'h37) == 0) return;
    end
  endtask

  task automatic runCmd(logic [31:0] c);
    wr(8'h00, c);
    waitIdle();
  endtask

  task automatic setAddr(logic [23:0] a);
    wr(8'h10, {24'h0, a[7:0]});
    wr(8'h14, {24'h0, a[15:8]});
    wr(8'h18, {24'h0, a[23:16]});
  endtask

  task automatic chkAddr(string req, logic [23:0] a);
    logic [31:0] lo, mi, hi;
    rd(8'h10, lo); rd(8'h14, mi); rd(8'h18, hi);
    check(req, {40'h0, hi[7:0], mi[7:0], lo[7:0]}, {40'h0, a});
  endtask

  initial begin
    logic [31:0] v;
    int fc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    monitorOn = 1'b1;

    // R1 reset state
    check("R1 csN", {63'h0, spiCsN}, 64'h1);
    check("R1 sck", {63'h0, spiSck}, 64'h0);
    rd(8'h00, v); check("R1 cmd", 64'(v), 64'h0);
    rd(8'h0C, v); check("R1 rdata", 64'(v), 64'h0);
    rd(8'hC4, v); check("R1 protect", 64'(v), 64'h0);

    // R2 locked: no frame, cmd stays zero
    fc = frameCount;
    wr(8'h00, 32'h01);
    rd(8'h00, v); check("R2 cmd locked", 64'(v), 64'h0);
    repeat (200) @(negedge clk);
    check("R2 no frame", 64'(frameCount), 64'(fc));
    wr(8'hC4, 32'h30);

    // R3 + R9 read with auto-increment and carry
    setAddr(24'h1234FF);
    pushFrame({24'h0, 8'h03, 24'h1234FF, 8'h00}, 40);
    wr(8'h00, 32'h81);
    rd(8'h00, v); check("R10 busy readback", 64'(v), 64'h81);
    wr(8'h00, 32'h02);
    rd(8'h00, v); check("R10 busy write ignored", 64'(v), 64'h81);
    waitIdle();
    rd(8'h0C, v); check("R3 read data", 64'(v), 64'(flashByte(24'h1234FF)));
    chkAddr("R9 carry increment", 24'h123500);

    // R3 read without auto-increment
    setAddr(24'h00A0C3);
    pushFrame({24'h0, 8'h03, 24'h00A0C3, 8'h00}, 40);
    runCmd(32'h01);
    rd(8'h0C, v); check("R3 read data 2", 64'(v), 64'(flashByte(24'h00A0C3)));
    chkAddr("R9 no increment without bit7", 24'h00A0C3);

    // R4 status read
    pushFrame({48'h0, 8'h05, 8'h00}, 16);
    runCmd(32'h02);
    rd(8'h08, v); check("R4 status", 64'(v), 64'hA5);

    // R5 byte write with auto-increment
    wr(8'h1C, 32'h3C);
    pushFrame(64'h06, 8);
    pushFrame({24'h0, 8'h02, 24'h00A0C3, 8'h3C}, 40);
    runCmd(32'h90);
    chkAddr("R9 write increment", 24'h00A0C4);

    // R6 status write
    pushFrame(64'h06, 8);
    pushFrame({48'h0, 8'h01, 8'h3C}, 16);
    runCmd(32'h20);

    // R7 program command: erase-style 32 bits, then 8, then 12
    wr(8'h34, 32'h20); wr(8'h30, 32'hAB); wr(8'h2C, 32'hCD); wr(8'h28, 32'hEF);
    wr(8'h04, 32'd32);
    pushFrame(64'h20ABCDEF, 32);
    runCmd(32'h84);
    chkAddr("R9 program ignores bit7", 24'h00A0C4);
    wr(8'h34, 32'h06); wr(8'h04, 32'd8);
    pushFrame(64'h06, 8);
    runCmd(32'h04);
    wr(8'h34, 32'hAB); wr(8'h30, 32'hCD); wr(8'h04, 32'd12);
    pushFrame(64'hABC, 12);
    runCmd(32'h04);

    // R8 bad counts
    fc = frameCount;
    wr(8'h04, 32'd0);
    runCmd(32'h04);
    rd(8'h00, v); check("R8 count zero clears", 64'(v), 64'h0);
    wr(8'h04, 32'd49);
    runCmd(32'h04);
    rd(8'h00, v); check("R8 count 49 clears", 64'(v), 64'h0);
    check("R8 no frame", 64'(frameCount), 64'(fc));

    // R11 two op bits: only bit 0 kept
    setAddr(24'h000010);
    pushFrame({24'h0, 8'h03, 24'h000010, 8'h00}, 40);
    wr(8'h00, 32'h05);
    rd(8'h00, v); check("R11 lowest bit kept", 64'(v), 64'h01);
    waitIdle();

    // R10 command on the completion edge is ignored
    fc = frameCount;
    pushFrame({24'h0, 8'h03, 24'h000010, 8'h00}, 40);
    wr(8'h00, 32'h01);
    repeat (40) @(posedge spiSck);
    @(negedge clk); @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h00; regWdata = 32'h02;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(8'h00, v); check("R10 cleared at completion", 64'(v), 64'h0);
    repeat (200) @(negedge clk);
    check("R10 completion-edge write ignored", 64'(frameCount), 64'(fc + 1));

    repeat (20) @(negedge clk);
    check("R3 all frames seen", 64'(expLen.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule